// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block predicts only whether a conditional branch is taken. It stores no branch targets. A shift register holds the outcomes of the most recent branches. That register is XORed with a slice of the lookup address, and the result indexes a table of 2-bit saturating counters. The table is held in a single-ported row memory. The logical table is tall and narrow, so it is folded into a roughly square array: each row holds several counters, and the low index bits pick one counter within the row.

A lookup takes three stages. In the request cycle, the whole cycle is spent forming the hashed index, which is then registered. In the next cycle the memory row is read. The prediction appears at the start of the cycle after that. The index used is returned with the prediction, so the front end can hand it back when the branch resolves. Training applies the resolved outcome to that index as a read-modify-write of one row. Because the array has one port, a training cycle takes the port away from any lookup that wanted to read in the same cycle. That lookup is dropped, and its slot shows up as a cycle with no valid prediction.

The history is shifted speculatively with every prediction delivered. After a mispredict, the front end reloads the history from a checkpoint it kept.

Top module: `gh_dir_predictor`

## Requirements
- R1: After synchronous reset, `pred_valid` is 0 and `ghist` is 0. Every counter starts at 1 (weakly not taken), so a lookup on an untrained index predicts not taken.
- R2: A lookup presented in cycle T gives `pred_valid` = 1 in cycle T+2, unless R5 applies. In that case `pred_idx` equals `lk_line XOR ghist`, both taken as they were in cycle T.
- R3: `pred_taken` is 1 exactly when the selected counter is 2 or 3. Counter values are 0, 1, 2 and 3.
- R4: A training update with `upd_taken` = 1 adds one to the counter and stops at 3. With `upd_taken` = 0 it subtracts one and stops at 0.
- R5: An update in cycle T+1 blocks the array read of a lookup presented in cycle T, so `pred_valid` is 0 in cycle T+2. An update in cycle T itself does not block that lookup.
- R6: An update in cycle U is seen by every lookup whose array read falls in cycle U+1 or later. This includes a lookup presented in cycle U.
- R7: On each cycle with `pred_valid` = 1, `ghist` shifts left by one at the next edge, and `pred_taken` enters at bit 0. With no prediction and no restore, `ghist` holds its value.
- R8: `rest_valid` loads `ghist` from `rest_hist` at the next edge. It wins over a shift in the same cycle.
- R9: Index bits [4:0] pick one of 32 counters in a row, and bits [11:5] pick one of 128 rows. Training one index leaves the other counters in its row unchanged.
- R10: `pred_valid` is never 1 unless a lookup was presented two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_line | input | 12 | Lookup address bits [13:2] |
| upd_valid | input | 1 | Training update request |
| upd_idx | input | 12 | Index returned with the prediction being trained |
| upd_taken | input | 1 | Resolved outcome of the branch |
| rest_valid | input | 1 | Reload the history from `rest_hist` |
| rest_hist | input | 12 | Checkpointed history value |
| pred_valid | output | 1 | A prediction is delivered this cycle |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_idx | output | 12 | Table index the prediction used |
| ghist | output | 12 | Current speculative history, newest outcome at bit 0 |

## Verification
A counter that steps wrongly or is written into the wrong row slot does not show at once. It shows the next time that index is looked up, as a wrong `pred_taken`. A fault of that kind then spreads, because each later `ghist` value and hashed `pred_idx` carries the wrong bit forward one cycle after delivery. A pipeline or port-conflict fault shows two cycles after the request, as a missing, extra or misindexed `pred_valid`. For this reason the reference model follows every cycle. It compares `ghist` on every cycle and compares `pred_valid` on every cycle, not only when a prediction is expected.

// File: rtl/gh_pkg.sv
package gh_pkg;

    localparam int GH_HIST_W   = 12;
    localparam int GH_ROW_CTRS = 32;
    localparam int CTR_W       = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX     = '1;
    localparam ctr_t CTR_WEAK_NT = ctr_t'(1);

    typedef enum logic [1:0] {
        HIST_HOLD  = 2'd0,
        HIST_SHIFT = 2'd1,
        HIST_LOAD  = 2'd2
    } hist_op_e;

    function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
        if (taken) return (c == CTR_MAX) ? c : ctr_t'(c + ctr_t'(1));
        else       return (c == '0)      ? c : ctr_t'(c - ctr_t'(1));
    endfunction

    function automatic logic ctr_says_taken(input ctr_t c);
        return c[CTR_W-1];
    endfunction

endpackage

// File: rtl/gh_hash_stage.sv
module gh_hash_stage #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [HIST_W-1:0] lk_line,
    input  logic [HIST_W-1:0] hist,
    output logic              s1_valid,
    output logic [HIST_W-1:0] s1_idx
);
    logic [HIST_W-1:0] hash_d;

    always_comb hash_d = hist ^ lk_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_idx   <= hash_d;
        end
    end
endmodule

// File: rtl/gh_counter_array.sv
module gh_counter_array
    import gh_pkg::*;
#(
    parameter int   IDX_W    = 12,
    parameter int   ROW_CTRS = 32,
    parameter ctr_t CTR_INIT = CTR_WEAK_NT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      upd_valid,
    input  logic [IDX_W-1:0]          upd_idx,
    input  logic                      upd_taken,
    output logic                      rd_valid,
    output logic [IDX_W-1:0]          rd_idx_q,
    output logic [ROW_CTRS*CTR_W-1:0] rd_row
);
    localparam int COL_W    = $clog2(ROW_CTRS);
    localparam int ROW_W    = IDX_W - COL_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int ROW_BITS = ROW_CTRS * CTR_W;

    typedef logic [ROW_BITS-1:0] row_t;

    row_t             mem [ROWS];
    logic [ROW_W-1:0] u_row, r_row;
    logic [COL_W-1:0] u_col;
    ctr_t             cur_ctr, nxt_ctr;
    row_t             wr_row;
    logic             rd_go;

    always_comb begin
        u_row   = upd_idx[IDX_W-1 -: ROW_W];
        u_col   = upd_idx[COL_W-1:0];
        r_row   = rd_idx[IDX_W-1 -: ROW_W];
        cur_ctr = mem[u_row][u_col*CTR_W +: CTR_W];
        nxt_ctr = ctr_next(cur_ctr, upd_taken);
        wr_row  = mem[u_row];
        wr_row[u_col*CTR_W +: CTR_W] = nxt_ctr;
        // the single port goes to training first
        rd_go   = rd_en && !upd_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= {ROW_CTRS{CTR_INIT}};
            rd_valid <= 1'b0;
            rd_idx_q <= '0;
            rd_row   <= '0;
        end else begin
            if (upd_valid) mem[u_row] <= wr_row;
            rd_valid <= rd_go;
            if (rd_go) begin
                rd_row   <= mem[r_row];
                rd_idx_q <= rd_idx;
            end
        end
    end

    // R4: a counter stays put only at the end it is pushed against
    p_sat_step_r4: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> ((nxt_ctr == cur_ctr) ==
                       (upd_taken ? (cur_ctr == CTR_MAX) : (cur_ctr == '0))));

    // R5: a read that collides with training yields no data
    p_block_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && upd_valid) |=> !rd_valid);

    // R6: a free port always serves the pending read
    p_read_served_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !upd_valid) |=> (rd_valid && rd_idx_q == $past(rd_idx)));
endmodule

// File: rtl/gh_history.sv
module gh_history
    import gh_pkg::*;
#(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_valid,
    input  logic              pred_taken,
    input  logic              rest_valid,
    input  logic [HIST_W-1:0] rest_hist,
    output logic [HIST_W-1:0] hist
);
    hist_op_e op;

    always_comb begin
        if (rest_valid)      op = HIST_LOAD;
        else if (pred_valid) op = HIST_SHIFT;
        else                 op = HIST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            case (op)
                HIST_LOAD:  hist <= rest_hist;
                HIST_SHIFT: hist <= {hist[HIST_W-2:0], pred_taken};
                default:    hist <= hist;
            endcase
        end
    end

    // R7: without a prediction or restore the history does not move
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!pred_valid && !rest_valid) |=> $stable(hist));

    // R8: restore lands exactly, even over a shift
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        rest_valid |=> (hist == $past(rest_hist)));
endmodule

// File: rtl/gh_dir_predictor.sv
module gh_dir_predictor
    import gh_pkg::*;
#(
    parameter int HIST_W   = GH_HIST_W,
    parameter int ROW_CTRS = GH_ROW_CTRS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [HIST_W-1:0] lk_line,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken,
    input  logic              rest_valid,
    input  logic [HIST_W-1:0] rest_hist,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_idx,
    output logic [HIST_W-1:0] ghist
);
    localparam int IDX_W = HIST_W;
    localparam int COL_W = $clog2(ROW_CTRS);

    logic                      s1_valid;
    logic [IDX_W-1:0]          s1_idx;
    logic                      rd_valid;
    logic [IDX_W-1:0]          rd_idx_q;
    logic [ROW_CTRS*CTR_W-1:0] rd_row;
    ctr_t                      row_ctrs [ROW_CTRS];
    ctr_t                      sel_ctr;

    gh_hash_stage #(.HIST_W(HIST_W)) u_hash (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_line  (lk_line),
        .hist     (ghist),
        .s1_valid (s1_valid),
        .s1_idx   (s1_idx)
    );

    gh_counter_array #(.IDX_W(IDX_W), .ROW_CTRS(ROW_CTRS)) u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (s1_valid),
        .rd_idx    (s1_idx),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_taken (upd_taken),
        .rd_valid  (rd_valid),
        .rd_idx_q  (rd_idx_q),
        .rd_row    (rd_row)
    );

    for (genvar c = 0; c < ROW_CTRS; c++) begin : g_unpack
        assign row_ctrs[c] = rd_row[c*CTR_W +: CTR_W];
    end

    always_comb begin
        sel_ctr    = row_ctrs[rd_idx_q[COL_W-1:0]];
        pred_valid = rd_valid;
        pred_idx   = rd_idx_q;
        pred_taken = rd_valid && ctr_says_taken(sel_ctr);
    end

    gh_history #(.HIST_W(HIST_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .pred_valid (pred_valid),
        .pred_taken (pred_taken),
        .rest_valid (rest_valid),
        .rest_hist  (rest_hist),
        .hist       (ghist)
    );

    // R10: no prediction without a request two cycles back
    p_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> $past(lk_valid, 2));

    // R2: delivered index is the hash formed at request time
    p_idx_hash_r2: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> (pred_idx == ($past(lk_line, 2) ^ $past(ghist, 2))));
endmodule

// File: tb/tb_gh_dir_predictor.sv
module tb_gh_dir_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int HW         = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0, rest_valid = 1'b0;
    logic [HW-1:0] lk_line = '0, upd_idx = '0, rest_hist = '0;
    logic          pred_valid, pred_taken;
    logic [HW-1:0] pred_idx, ghist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gh_dir_predictor dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_line(lk_line),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
        .rest_valid(rest_valid), .rest_hist(rest_hist),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_idx(pred_idx), .ghist(ghist)
    );

    typedef struct {
        int          due;
        bit          valid;
        bit [HW-1:0] idx;
        bit          taken;
    } exp_t;

    exp_t        sb_q[$];
    int          cyc = 0;
    int          n_run = 0, n_fail = 0;
    bit [HW-1:0] m_hist = '0;
    bit [1:0]    m_ctr [1<<HW];
    bit          mp_v = 0;
    bit [HW-1:0] mp_idx = '0;
    bit          last_rest = 0;
    string       tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one cycle: monitor current outputs, then drive and advance model
    task automatic step(input bit lk, input bit [HW-1:0] tgt,
                        input bit up, input bit [HW-1:0] ui, input bit ut,
                        input bit rv, input bit [HW-1:0] rh);
        exp_t        head, e;
        bit          have;
        bit [HW-1:0] nh;
        @(negedge clk);
        have = (sb_q.size() > 0) && (sb_q[0].due == cyc);
        if (have) begin
            head = sb_q.pop_front();
            chk(pred_valid == head.valid, head.valid ? "R2" : "R5", "pred_valid",
                int'(pred_valid), int'(head.valid));
            if (head.valid && pred_valid) begin
                chk(pred_idx == head.idx, "R2", "pred_idx", int'(pred_idx), int'(head.idx));
                chk(pred_taken == head.taken, tag, "pred_taken",
                    int'(pred_taken), int'(head.taken));
            end
        end else begin
            chk(pred_valid == 1'b0, "R10", "pred_valid idle", int'(pred_valid), 0);
        end
        chk(ghist == m_hist, last_rest ? "R8" : "R7", "ghist", int'(ghist), int'(m_hist));

        lk_valid   = lk;
        lk_line    = tgt ^ m_hist;
        upd_valid  = up;
        upd_idx    = ui;
        upd_taken  = ut;
        rest_valid = rv;
        rest_hist  = rh;

        if (mp_v) begin
            e.due   = cyc + 1;
            e.valid = !up;
            e.idx   = mp_idx;
            e.taken = up ? 1'b0 : m_ctr[mp_idx][1];
            sb_q.push_back(e);
        end
        mp_v   = lk;
        mp_idx = tgt;
        if (up) begin
            if (ut) m_ctr[ui] = (m_ctr[ui] == 2'd3) ? 2'd3 : m_ctr[ui] + 2'd1;
            else    m_ctr[ui] = (m_ctr[ui] == 2'd0) ? 2'd0 : m_ctr[ui] - 2'd1;
        end
        nh = m_hist;
        if (have && head.valid) nh = {m_hist[HW-2:0], head.taken};
        if (rv) nh = rh;
        m_hist    = nh;
        last_rest = rv;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, 0, '0);
    endtask

    task automatic look(input bit [HW-1:0] t);
        step(1, t, 0, '0, 0, 0, '0);
        idle(2);
    endtask

    task automatic train(input bit [HW-1:0] i, input bit t, input int n);
        for (int k = 0; k < n; k++) step(0, '0, 1, i, t, 0, '0);
    endtask

    initial begin
        repeat (1 << HW) begin end
        for (int i = 0; i < (1 << HW); i++) m_ctr[i] = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(pred_valid == 1'b0, "R1", "pred_valid after reset", int'(pred_valid), 0);
        chk(ghist == '0, "R1", "ghist after reset", int'(ghist), 0);

        tag = "R1";
        look(12'h0A5);
        look(12'hF3C);

        // R4: climb to saturation, then step down
        tag = "R4";
        train(12'h123, 1, 6);
        look(12'h123);
        tag = "R3";
        train(12'h123, 0, 1);
        look(12'h123);
        train(12'h123, 0, 1);
        look(12'h123);
        tag = "R4";
        train(12'h123, 0, 5);
        train(12'h123, 1, 1);
        look(12'h123);

        // R5: update right after a request blocks it; same-cycle does not
        tag = "R5";
        step(1, 12'h200, 0, '0, 0, 0, '0);
        step(0, '0, 1, 12'h7FF, 1, 0, '0);
        idle(2);
        step(1, 12'h201, 1, 12'h7FE, 1, 0, '0);
        idle(2);

        // R6: update in the request cycle is seen by that lookup
        tag = "R6";
        step(1, 12'h3C3, 1, 12'h3C3, 1, 0, '0);
        idle(2);

        // R9: row neighbours unaffected
        tag = "R9";
        train(12'h140, 1, 3);
        look(12'h141);
        look(12'h15F);
        look(12'h140);

        // R8: restore overriding a shift in the same cycle
        tag = "R8";
        step(1, 12'h140, 0, '0, 0, 0, '0);
        step(0, '0, 0, '0, 0, 0, '0);
        step(0, '0, 0, '0, 0, 1, 12'hABC);
        look(12'h140);
        step(0, '0, 0, '0, 0, 1, 12'h555);
        look(12'h0F0);

        // mixed traffic
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            automatic bit [HW-1:0] t = 12'($urandom) & 12'h0FF;
            step(($urandom % 4) != 0, t,
                 ($urandom % 3) == 0, 12'($urandom) & 12'h0FF, $urandom % 2,
                 ($urandom % 40) == 0, 12'($urandom));
        end
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule